// File: doc/BRIEF.md
# Four-channel DMA transfer controller

This block is a bus-master DMA engine with four peripheral request channels. The processor programs it through a byte-wide slave port gated by an active-low chip select. Each channel has a 16-bit start address and a 16-bit count, and the port also holds an enable/priority mode word, a per-channel direction word and a status word. A 16-bit value is loaded or read as two successive byte accesses, low byte first. An internal byte-order toggle decides which half each access touches.

When an enabled channel raises its request, the engine raises its bus request. It waits for the processor's hold acknowledge, then arbitrates among the pending channels with fixed or rotating priority. For each byte it runs one bus cycle:
- It places the upper address byte on the data bus with a latch strobe, and drives the lower address byte on dedicated lines.
- It holds the winning channel's active-low acknowledge.
- It pulses the memory/IO strobe pair that the channel's direction selects.

After each byte the address steps up by one and the count steps down by one. When the count passes zero, a one-cycle terminal-count pulse is produced, a sticky status bit is set and the channel disables itself. The engine gives the bus back after every byte and asks again for the next one.

Slave register select (`reg_sel`):
- 2c is channel c's address.
- 2c+1 is channel c's count.
- 8 writes the mode word or reads the status word.
- 9 is the direction word.

The mode word has the channel enables in bits 3:0 and rotating priority in bit 4. The status word has the sticky terminal-count flags in bits 3:0 and the update flag in bit 4. In the direction word, bit c = 1 means memory to peripheral (memory read plus IO write). Bit c = 0 means peripheral to memory (IO read plus memory write).

Top module: `dma4_engine`

## Requirements
- R1: After reset `hrq` is low, every `dack_n` bit and every strobe is high, the status word reads 0 and all channels are disabled, so a request on `dreq` does not raise `hrq`.
- R2: A channel address or count is written and read back as two byte accesses, low byte first. A write to the mode word (select 8) returns the byte-order toggle to the low byte.
- R3: An enabled channel's request raises `hrq`. No acknowledge, address strobe or read/write strobe appears until `hlda` has been seen high.
- R4: With mode bit 4 clear, the lowest-numbered pending channel is served first, and it keeps the bus for every byte for as long as it stays pending.
- R5: With mode bit 4 set, the channel just served becomes the lowest priority. A write to the mode word makes channel 0 the highest again.
- R6: Each byte cycle begins with a one-cycle `adstb` pulse. During that pulse `data_out` carries address bits 15:8 with `data_oe` high, `addr_low` carries address bits 7:0, and only the served channel's `dack_n` bit is low.
- R7: The cycle after `adstb`, direction bit 1 drives `memr_n` and `iow_n` low, and direction bit 0 drives `ior_n` and `memw_n` low. The other pair stays high.
- R8: A count of N-1 yields exactly N bytes at consecutive addresses, with carry into the upper byte. `tc` pulses for one cycle after the last byte only. The channel then disables itself, and its registers read back address+N and count 16'hFFFF.
- R9: Status bits 3:0 are set by a channel's terminal count and stay set until a status read, which returns them and then clears them. Status bit 4 reads 1 while the high byte of a two-byte access is pending.
- R10: Slave accesses with `cs_n` high, or while `hlda` is high, change no register and no byte-order toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select for slave accesses |
| rd_n | input | 1 | Active-low slave read strobe |
| wr_n | input | 1 | Active-low slave write strobe |
| reg_sel | input | 4 | Slave register select |
| data_in | input | 8 | Slave write data |
| data_out | output | 8 | Slave read data, or address bits 15:8 during `adstb` |
| data_oe | output | 1 | Data bus drive enable |
| dreq | input | 4 | Peripheral requests, one per channel |
| dack_n | output | 4 | Active-low per-channel acknowledge |
| hrq | output | 1 | Bus request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| adstb | output | 1 | Upper-address latch strobe |
| addr_low | output | 8 | Address bits 7:0 |
| memr_n | output | 1 | Active-low memory read strobe |
| memw_n | output | 1 | Active-low memory write strobe |
| ior_n | output | 1 | Active-low IO read strobe |
| iow_n | output | 1 | Active-low IO write strobe |
| tc | output | 1 | Terminal-count pulse |

## Verification
The interesting overlap is two channels becoming eligible in the same cycle, which happens while a mode write also resets the rotation pointer. It is provoked by holding two requests high and enabling both channels with a single mode write. The bench then judges the order of served channels from the acknowledge recorded at each `adstb` pulse, which gives one order in fixed mode and an alternating order in rotating mode. The terminal count of one channel landing while another is still pending is judged in the same runs. The bench checks that the pulse follows only the last byte of the finished channel and that the other channel continues.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef logic [15:0] word_t;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_XFER,
    ST_DONE
  } dma_state_e;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [3:0]     sel,
  input  logic [7:0]     wdata,
  input  logic           bus_owned,
  input  logic           upd_en,
  input  logic [CHW-1:0] upd_ch,
  input  word_t          upd_addr,
  input  word_t          upd_cnt,
  input  logic           upd_tc,
  output logic [7:0]     rdata,
  output logic           rd_act,
  output word_t          ch_addr [NCH],
  output word_t          ch_cnt  [NCH],
  output logic [NCH-1:0] en,
  output logic [NCH-1:0] dir,
  output logic           rotate,
  output logic           prio_reset
);
  localparam logic [3:0] SEL_MODE = 4'(2 * NCH);
  localparam logic [3:0] SEL_DIR  = 4'(2 * NCH + 1);

  logic           acc, wr_acc, is_chreg, ff_q;
  logic [NCH-1:0] tc_q;
  logic [CHW-1:0] wch;
  word_t          sel_word;

  assign acc        = !cs_n && !bus_owned;
  assign wr_acc     = acc && !wr_n;
  assign rd_act     = acc && !rd_n && wr_n;
  assign is_chreg   = sel < SEL_MODE;
  assign wch        = sel[CHW:1];
  assign prio_reset = wr_acc && (sel == SEL_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ch_addr[i] <= '0;
        ch_cnt[i]  <= '0;
      end
      en     <= '0;
      dir    <= '0;
      rotate <= 1'b0;
      ff_q   <= 1'b0;
      tc_q   <= '0;
    end else begin
      if (wr_acc && is_chreg) begin
        if (sel[0]) begin
          if (ff_q) ch_cnt[wch][15:8] <= wdata;
          else      ch_cnt[wch][7:0]  <= wdata;
        end else begin
          if (ff_q) ch_addr[wch][15:8] <= wdata;
          else      ch_addr[wch][7:0]  <= wdata;
        end
        ff_q <= !ff_q;
      end else if (rd_act && is_chreg) begin
        ff_q <= !ff_q;
      end
      if (wr_acc && sel == SEL_MODE) begin
        en     <= wdata[NCH-1:0];
        rotate <= wdata[NCH];
        ff_q   <= 1'b0;
      end
      if (wr_acc && sel == SEL_DIR) dir <= wdata[NCH-1:0];
      if (rd_act && sel == SEL_MODE) tc_q <= '0;
      if (upd_en) begin
        ch_addr[upd_ch] <= upd_addr;
        ch_cnt[upd_ch]  <= upd_cnt;
        if (upd_tc) begin
          en[upd_ch]   <= 1'b0;
          tc_q[upd_ch] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    sel_word = sel[0] ? ch_cnt[wch] : ch_addr[wch];
    rdata    = '0;
    if (is_chreg) begin
      rdata = ff_q ? sel_word[15:8] : sel_word[7:0];
    end else if (sel == SEL_MODE) begin
      rdata[NCH-1:0] = tc_q;
      rdata[NCH]     = ff_q;
    end else if (sel == SEL_DIR) begin
      rdata[NCH-1:0] = dir;
    end
  end

  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(tc_q) & ~tc_q) != '0) |-> $past(rd_act && sel == SEL_MODE)); // R9
  AST_IGNORED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n || bus_owned) && !upd_en) |=>
      ($stable(en) && $stable(dir) && $stable(rotate) && $stable(ff_q))); // R10
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic           take,
  input  logic           ptr_reset,
  output logic           gnt_valid,
  output logic [CHW-1:0] gnt_idx
);
  logic [CHW-1:0] last_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < NCH; i++) begin
      int k;
      k = rotate ? ((int'(last_q) + 1 + i) % NCH) : i;
      if (!gnt_valid && req[k]) begin
        gnt_valid = 1'b1;
        gnt_idx   = CHW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_reset) last_q <= CHW'(NCH - 1);
    else if (take && rotate) last_q <= gnt_idx;
  end

  AST_GNT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]); // R4
  AST_FIXED_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && req[0]) |-> (gnt_valid && gnt_idx == '0)); // R4
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hlda,
  input  logic           gnt_valid,
  input  logic [CHW-1:0] gnt_idx,
  input  word_t          ch_addr [NCH],
  input  word_t          ch_cnt  [NCH],
  input  logic [NCH-1:0] dir,
  output logic           hrq,
  output logic           take,
  output logic           adstb,
  output logic [7:0]     addr_hi,
  output logic [7:0]     addr_low,
  output logic [NCH-1:0] dack_n,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic           tc,
  output logic           upd_en,
  output logic [CHW-1:0] upd_ch,
  output word_t          upd_addr,
  output word_t          upd_cnt,
  output logic           upd_tc
);
  dma_state_e     state;
  logic [CHW-1:0] cur_ch;
  word_t          cur_addr, cur_cnt;
  logic           cur_dir, last_q, strobe;
  logic [NCH-1:0] sel_oh;

  assign take = (state == ST_REQ) && gnt_valid && hlda;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_ch   <= '0;
      cur_addr <= '0;
      cur_cnt  <= '0;
      cur_dir  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (gnt_valid) state <= ST_REQ;
        ST_REQ: begin
          if (!gnt_valid) state <= ST_IDLE;
          else if (hlda) begin
            state    <= ST_ADDR;
            cur_ch   <= gnt_idx;
            cur_addr <= ch_addr[gnt_idx];
            cur_cnt  <= ch_cnt[gnt_idx];
            cur_dir  <= dir[gnt_idx];
          end
        end
        ST_ADDR: state <= ST_XFER;
        ST_XFER: begin
          state  <= ST_DONE;
          last_q <= (cur_cnt == '0);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_oh         = '0;
    sel_oh[cur_ch] = 1'b1;
  end

  assign hrq      = (state != ST_IDLE);
  assign adstb    = (state == ST_ADDR);
  assign strobe   = (state == ST_XFER);
  assign addr_hi  = cur_addr[15:8];
  assign addr_low = cur_addr[7:0];
  assign dack_n   = (adstb || strobe) ? ~sel_oh : '1;
  assign memr_n   = !(strobe && cur_dir);
  assign iow_n    = !(strobe && cur_dir);
  assign ior_n    = !(strobe && !cur_dir);
  assign memw_n   = !(strobe && !cur_dir);
  assign tc       = (state == ST_DONE) && last_q;
  assign upd_en   = strobe;
  assign upd_ch   = cur_ch;
  assign upd_addr = cur_addr + 16'd1;
  assign upd_cnt  = cur_cnt - 16'd1;
  assign upd_tc   = (cur_cnt == '0);

  AST_ONE_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n)); // R6
  AST_DACK_NEEDS_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_n != '1) |-> hrq); // R3
  AST_GRANT_BEFORE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adstb) |-> $past(hlda)); // R3
  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc); // R8
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!memr_n || !iow_n) |-> (memw_n && ior_n)); // R7
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [3:0]     reg_sel,
  input  logic [7:0]     data_in,
  output logic [7:0]     data_out,
  output logic           data_oe,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack_n,
  output logic           hrq,
  input  logic           hlda,
  output logic           adstb,
  output logic [7:0]     addr_low,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic           tc
);
  word_t          ch_addr [NCH];
  word_t          ch_cnt  [NCH];
  logic [NCH-1:0] en, dir;
  logic           rotate, prio_reset, rd_act, take, gnt_valid;
  logic           upd_en, upd_tc;
  logic [CHW-1:0] gnt_idx, upd_ch;
  word_t          upd_addr, upd_cnt;
  logic [7:0]     rdata, addr_hi;

  dma4_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel(reg_sel), .wdata(data_in), .bus_owned(hlda),
    .upd_en(upd_en), .upd_ch(upd_ch), .upd_addr(upd_addr),
    .upd_cnt(upd_cnt), .upd_tc(upd_tc),
    .rdata(rdata), .rd_act(rd_act), .ch_addr(ch_addr), .ch_cnt(ch_cnt),
    .en(en), .dir(dir), .rotate(rotate), .prio_reset(prio_reset)
  );

  dma4_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(dreq & en), .rotate(rotate),
    .take(take), .ptr_reset(prio_reset),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  dma4_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .hlda(hlda),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .ch_addr(ch_addr), .ch_cnt(ch_cnt), .dir(dir),
    .hrq(hrq), .take(take), .adstb(adstb), .addr_hi(addr_hi),
    .addr_low(addr_low), .dack_n(dack_n),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
    .tc(tc), .upd_en(upd_en), .upd_ch(upd_ch), .upd_addr(upd_addr),
    .upd_cnt(upd_cnt), .upd_tc(upd_tc)
  );

  assign data_out = adstb ? addr_hi : rdata;
  assign data_oe  = adstb || rd_act;

  AST_LATCH_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> (data_oe && !rd_act)); // R6
endmodule

// File: tb/tb_dma4_engine.sv
module tb_dma4_engine;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] reg_sel = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic [3:0] dreq = '0;
  logic [3:0] dack_n;
  logic       hrq, hlda, adstb, memr_n, memw_n, ior_n, iow_n, tc;
  logic [7:0] addr_low;
  logic       hold_block = 1'b0, hlda_force = 1'b0;

  int nchk = 0, nfail = 0, nlog = 0;
  int         log_ch   [32];
  logic [15:0] log_addr [32];
  logic [3:0] log_strb [32];
  logic       log_tc   [32];

  always #(CLK_P / 2) clk = ~clk;

  dma4_engine dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dreq(dreq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda), .adstb(adstb),
    .addr_low(addr_low), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
    .iow_n(iow_n), .tc(tc)
  );

  // processor model: grants the bus one cycle after the request
  always @(posedge clk) begin
    if (!rst_n) hlda <= 1'b0;
    else hlda <= (hrq && !hold_block) || hlda_force;
  end

  // bus-cycle monitor
  always @(negedge clk) begin
    if (rst_n && adstb && nlog < 32) begin
      log_ch[nlog] = -1;
      for (int i = 0; i < 4; i++) if (!dack_n[i]) log_ch[nlog] = i;
      log_addr[nlog] = {data_out, addr_low};
      log_strb[nlog] = 4'hF;
      log_tc[nlog]   = 1'b0;
      nlog++;
    end
    if (rst_n && nlog > 0 && !(memr_n && memw_n && ior_n && iow_n))
      log_strb[nlog-1] = {memr_n, memw_n, ior_n, iow_n};
    if (rst_n && nlog > 0 && tc) log_tc[nlog-1] = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; reg_sel = s; data_in = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; reg_sel = s;
    #(CLK_P / 4);
    d = data_out;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wr16(input logic [3:0] s, input logic [15:0] v);
    wr_reg(s, v[7:0]);
    wr_reg(s, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] s, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(s, lo);
    rd_reg(s, hi);
    v = {hi, lo};
  endtask

  task automatic wait_xfers(input int target);
    int t = 0;
    while (nlog < target && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] st;
    chk("R1 hrq", hrq, 0);
    chk("R1 dack_n", dack_n, 4'hF);
    chk("R1 strobes", {memr_n, memw_n, ior_n, iow_n, adstb, tc}, 6'b111100);
    rd_reg(4'd8, st);
    chk("R1 status", st, 0);
    dreq = 4'hF;
    repeat (5) @(negedge clk);
    chk("R1 disabled channels no hrq", hrq, 0);
    dreq = 4'h0;
  endtask

  task automatic t_program;
    logic [7:0]  st;
    logic [15:0] v;
    wr_reg(4'd2, 8'h34);
    rd_reg(4'd8, st);
    chk("R9 update flag mid access", st[4], 1);
    wr_reg(4'd2, 8'h12);
    rd_reg(4'd8, st);
    chk("R9 update flag after pair", st[4], 0);
    rd16(4'd2, v);
    chk("R2 address readback", v, 16'h1234);
    wr16(4'd3, 16'hBEEF);
    rd16(4'd3, v);
    chk("R2 count readback", v, 16'hBEEF);
    wr_reg(4'd4, 8'h77);
    wr_reg(4'd8, 8'h00);
    rd_reg(4'd8, st);
    chk("R2 mode write resets toggle", st[4], 0);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    wr_reg(4'd2, 8'hAA, 1'b1);
    rd16(4'd2, v);
    chk("R10 cs_n high write ignored", v, 16'h1234);
    hlda_force = 1'b1;
    repeat (2) @(negedge clk);
    wr_reg(4'd2, 8'h55);
    hlda_force = 1'b0;
    repeat (2) @(negedge clk);
    rd16(4'd2, v);
    chk("R10 write during hlda ignored", v, 16'h1234);
  endtask

  task automatic t_hold;
    int base = nlog;
    wr16(4'd0, 16'h4000);
    wr16(4'd1, 16'h0000);
    hold_block = 1'b1;
    dreq[0] = 1'b1;
    wr_reg(4'd8, 8'h01);
    repeat (6) @(negedge clk);
    chk("R3 hrq raised", hrq, 1);
    chk("R3 no dack before hlda", dack_n, 4'hF);
    chk("R3 no cycle before hlda", nlog, base);
    hold_block = 1'b0;
    wait_xfers(base + 1);
    chk("R3 cycle after grant", nlog, base + 1);
    chk("R3 address", log_addr[base], 16'h4000);
    dreq = 4'h0;
  endtask

  task automatic t_single;
    logic [7:0]  st;
    logic [15:0] v;
    int base;
    rd_reg(4'd8, st);
    base = nlog;
    wr16(4'd0, 16'hA5F0);
    wr16(4'd1, 16'd2);
    wr_reg(4'd9, 8'h01);
    dreq[0] = 1'b1;
    wr_reg(4'd8, 8'h01);
    wait_xfers(base + 3);
    repeat (20) @(negedge clk);
    chk("R8 exactly three bytes", nlog, base + 3);
    for (int i = 0; i < 3; i++) begin
      chk("R6 channel", log_ch[base+i], 0);
      chk("R6 address", log_addr[base+i], 16'hA5F0 + i);
      chk("R7 read-memory strobes", log_strb[base+i], 4'b0110);
      chk("R8 tc only on last", log_tc[base+i], (i == 2) ? 1 : 0);
    end
    chk("R8 hrq dropped after disable", hrq, 0);
    dreq = 4'h0;
    rd16(4'd0, v);
    chk("R8 address after", v, 16'hA5F3);
    rd16(4'd1, v);
    chk("R8 count after", v, 16'hFFFF);
    rd_reg(4'd8, st);
    chk("R9 tc flag set", st, 8'h01);
    rd_reg(4'd8, st);
    chk("R9 tc flag cleared by read", st, 8'h00);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    int base = nlog;
    wr16(4'd6, 16'h00FF);
    wr16(4'd7, 16'h0000);
    wr_reg(4'd9, 8'h08);
    dreq[3] = 1'b1;
    wr_reg(4'd8, 8'h08);
    wait_xfers(base + 1);
    dreq = 4'h0;
    chk("R8 wrap one byte", nlog, base + 1);
    chk("R6 channel 3", log_ch[base], 3);
    chk("R6 upper byte on data bus", log_addr[base], 16'h00FF);
    rd16(4'd6, v);
    chk("R8 carry into upper byte", v, 16'h0100);
  endtask

  task automatic t_arb(input logic rot);
    logic [7:0] st;
    int base, exp_ch[4];
    rd_reg(4'd8, st);
    base = nlog;
    wr16(4'd2, 16'h0100);
    wr16(4'd3, 16'd1);
    wr16(4'd4, 16'h0200);
    wr16(4'd5, 16'd1);
    wr_reg(4'd9, 8'h00);
    dreq = 4'b0110;
    wr_reg(4'd8, rot ? 8'h16 : 8'h06);
    wait_xfers(base + 4);
    dreq = 4'h0;
    chk(rot ? "R5 count" : "R4 count", nlog, base + 4);
    exp_ch = rot ? '{1, 2, 1, 2} : '{1, 1, 2, 2};
    for (int i = 0; i < 4; i++) begin
      chk(rot ? "R5 order" : "R4 order", log_ch[base+i], exp_ch[i]);
      chk("R7 write-memory strobes", log_strb[base+i], 4'b1001);
    end
    chk(rot ? "R5 tc ch1" : "R4 tc ch1", log_tc[base + (rot ? 2 : 1)], 1);
    chk(rot ? "R5 no tc" : "R4 no tc", log_tc[base], 0);
    rd_reg(4'd8, st);
    chk("R9 both tc flags", st, 8'h06);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program();
    t_ignored();
    t_hold();
    t_single();
    t_wrap();
    t_arb(1'b0);
    t_arb(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule